// File: doc/BRIEF.md
# Sixteen-Pin Four-Mode GPIO Port

This block controls a bank of sixteen general-purpose pins. Each pin has its own two-bit mode and can be a high-impedance input, a push-pull output, an open-drain output or a quasi-bidirectional pin. From the mode and the pin's output bit the block derives three pad controls per pin: the value driven, a strong-drive enable and a weak pull-up enable. Pad inputs are brought into the clock domain through a two-flop synchronizer. The synchronized values can be read back, and they feed a per-pin interrupt detector that works on edges or on levels.

Software reaches the block through a word-wide bus with a one-cycle write strobe and a combinational read. A strap input chooses the mode that every pin takes out of reset: all inputs or all quasi-bidirectional. An enabled pin interrupt also drives that pin's wake-up request. A per-pin input-buffer type bit (TTL or Schmitt) is held in a register and passed straight out to the pads. The asynchronous active-low reset is released through an internal two-stage synchronizer.

Top module: `gpio_quad_port`

## Requirements
- R1: Mode encoding is 2'b00 input, 2'b01 push-pull, 2'b10 open-drain and 2'b11 quasi-bidirectional, with pin i's field at MODE (address 0) bits [2i+1:2i]. In push-pull the strong drive is on and the pad value equals the pin's output bit (DOUT, address 1, bit i). No pin drives a strong high in any other mode.
- R2: In open-drain, an output bit of 0 drives a strong low (oe=1, out=0) and an output bit of 1 turns the strong drive off. The pull-up is off in both cases.
- R3: In quasi-bidirectional mode the pad value is 0 and the strong drive equals the inverted output bit, so a 1 releases the pin. The weak pull-up is on.
- R4: In input mode the strong drive and the pull-up are both off. For every mode, the level on a pad appears in PIN (address 2, read-only) after the second rising clock edge following its change, and not after the first.
- R5: After reset with strap 0, MODE reads 0x00000000 and every pin is an input. With strap 1, MODE reads 0xFFFFFFFF, every pin is quasi-bidirectional and every pull-up is on. DOUT resets to 0xFFFF, and the interrupt enable, type, polarity and pending registers reset to 0.
- R6: A weak pull-up is enabled only on pins in quasi-bidirectional mode. It is never on at the same time as a strong high on the same pin.
- R7: For an enabled pin with ITYPE (address 4) bit 0, a rising edge latches the IPEND (address 6) bit when IPOL (address 5) bit is 1, and a falling edge latches it when that bit is 0. The opposite edge is ignored. The bit becomes readable after the third rising clock edge after the pad change.
- R8: Writing 1 to an IPEND bit clears a latched edge event. Bits written 0 are left unchanged.
- R9: With ITYPE bit 1, the IPEND bit of an enabled pin reads 1 exactly while the synchronized pin level equals the IPOL bit. A write of 1 does not clear it.
- R10: Only pins with their IEN (address 3) bit set raise pending bits. The irq output is the OR of the pending bits of enabled pins.
- R11: wake_req[i] is 1 exactly when pin i is enabled and pending, so enabling the interrupt also arms the wake-up.
- R12: pad_schmitt equals the buffer-type register (address 7) bit for bit.
- R13: Reads of addresses 8 and above return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_quasi | input | 1 | Reset mode select: 0 input, 1 quasi-bidirectional |
| bus_sel | input | 1 | Bus access strobe |
| bus_we | input | 1 | Write qualifier |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| pad_in | input | 16 | Raw pad levels |
| pad_out | output | 16 | Value driven when the strong drive is on |
| pad_oe | output | 16 | Strong-drive enable |
| pad_pu | output | 16 | Weak pull-up enable |
| pad_schmitt | output | 16 | Input buffer type select |
| irq | output | 1 | Port interrupt |
| wake_req | output | 16 | Per-pin wake-up request |

## Verification
A wrong mode field shows up at once on pad_oe, pad_out and pad_pu, in the same cycle that the faulty register value takes effect. A bad synchronizer or edge-history flop shows up as a PIN readback or pending bit that appears one cycle early, one cycle late or never. The bench samples both the cycle before and the cycle of the expected change. A pending bit that is set wrongly or not cleared is seen on irq and wake_req in the following cycle, and it stays visible there until a write of 1 clears it.

// File: rtl/gpio_quad_pkg.sv
package gpio_quad_pkg;
  typedef enum logic [1:0] {
    PM_INPUT  = 2'b00,
    PM_PUSH   = 2'b01,
    PM_ODRAIN = 2'b10,
    PM_QUASI  = 2'b11
  } pin_mode_e;

  localparam int REG_AW = 4;

  localparam logic [REG_AW-1:0] A_MODE  = 4'd0;
  localparam logic [REG_AW-1:0] A_DOUT  = 4'd1;
  localparam logic [REG_AW-1:0] A_PIN   = 4'd2;
  localparam logic [REG_AW-1:0] A_IEN   = 4'd3;
  localparam logic [REG_AW-1:0] A_ITYPE = 4'd4;
  localparam logic [REG_AW-1:0] A_IPOL  = 4'd5;
  localparam logic [REG_AW-1:0] A_IPEND = 4'd6;
  localparam logic [REG_AW-1:0] A_BUF   = 4'd7;
endpackage

// File: rtl/gpio_rst_sync.sv
module gpio_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stg0_q, stg1_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg0_q <= 1'b0;
      stg1_q <= 1'b0;
    end else begin
      stg0_q <= 1'b1;
      stg1_q <= stg0_q;
    end
  end

  assign rst_sync_n = stg1_q;
endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int NPIN = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPIN-1:0] d_in,
  output logic [NPIN-1:0] q_out
);
  logic [NPIN-1:0] meta_q, meta_d, stab_q, stab_d;

  always_comb begin
    meta_d = d_in;
    stab_d = meta_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      stab_q <= '0;
    end else begin
      meta_q <= meta_d;
      stab_q <= stab_d;
    end
  end

  assign q_out = stab_q;
endmodule

// File: rtl/gpio_pad_ctrl.sv
module gpio_pad_ctrl
  import gpio_quad_pkg::*;
#(
  parameter int NPIN = 16
) (
  input  logic [2*NPIN-1:0] mode_vec,
  input  logic [NPIN-1:0]   dout,
  output logic [NPIN-1:0]   pad_out,
  output logic [NPIN-1:0]   pad_oe,
  output logic [NPIN-1:0]   pad_pu
);
  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    always_comb begin
      pad_out[i] = 1'b0;
      pad_oe[i]  = 1'b0;
      pad_pu[i]  = 1'b0;
      case (pin_mode_e'(mode_vec[2*i +: 2]))
        PM_PUSH: begin
          pad_oe[i]  = 1'b1;
          pad_out[i] = dout[i];
        end
        PM_ODRAIN: begin
          pad_oe[i]  = ~dout[i];
        end
        PM_QUASI: begin
          pad_oe[i]  = ~dout[i];
          pad_pu[i]  = 1'b1;
        end
        default: begin
          pad_oe[i]  = 1'b0;
        end
      endcase
    end
  end
endmodule

// File: rtl/gpio_irq_det.sv
module gpio_irq_det #(
  parameter int NPIN = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPIN-1:0] lvl,
  input  logic [NPIN-1:0] ien,
  input  logic [NPIN-1:0] itype,
  input  logic [NPIN-1:0] ipol,
  input  logic [NPIN-1:0] clr_mask,
  output logic [NPIN-1:0] pend
);
  logic [NPIN-1:0] prev_q, prev_d;
  logic [NPIN-1:0] edge_pend_q, edge_pend_d;
  logic [NPIN-1:0] rise, fall, hit, lvl_match;

  always_comb begin
    rise        = lvl & ~prev_q;
    fall        = ~lvl & prev_q;
    hit         = ien & ~itype & ((ipol & rise) | (~ipol & fall));
    edge_pend_d = (edge_pend_q & ~clr_mask) | hit;
    prev_d      = lvl;
    lvl_match   = ~(lvl ^ ipol);
    pend        = (ien & itype & lvl_match) | (~itype & edge_pend_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q      <= '0;
      edge_pend_q <= '0;
    end else begin
      prev_q      <= prev_d;
      edge_pend_q <= edge_pend_d;
    end
  end

  for (genvar i = 0; i < NPIN; i++) begin : g_chk
    // R10
    edge_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(edge_pend_q[i]) |-> $past(ien[i]));
  end
endmodule

// File: rtl/gpio_quad_port.sv
module gpio_quad_port
  import gpio_quad_pkg::*;
#(
  parameter int NPIN = 16,
  parameter int DW   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strap_quasi,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [REG_AW-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  input  logic [NPIN-1:0]   pad_in,
  output logic [NPIN-1:0]   pad_out,
  output logic [NPIN-1:0]   pad_oe,
  output logic [NPIN-1:0]   pad_pu,
  output logic [NPIN-1:0]   pad_schmitt,
  output logic              irq,
  output logic [NPIN-1:0]   wake_req
);
  localparam int MW = 2 * NPIN;

  logic            rst_sync_n;
  logic            wr;
  logic [MW-1:0]   mode_q, mode_d, mode_eff, strap_mode;
  logic            use_strap_q, use_strap_d;
  logic [NPIN-1:0] dout_q, dout_d;
  logic [NPIN-1:0] ien_q, ien_d;
  logic [NPIN-1:0] itype_q, itype_d;
  logic [NPIN-1:0] ipol_q, ipol_d;
  logic [NPIN-1:0] buf_q, buf_d;
  logic [NPIN-1:0] clr_mask;
  logic [NPIN-1:0] pin_sync;
  logic [NPIN-1:0] pend;

  gpio_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  gpio_sync #(.NPIN(NPIN)) u_sync (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .d_in  (pad_in),
    .q_out (pin_sync)
  );

  assign strap_mode = {NPIN{{2{strap_quasi}}}};
  assign mode_eff   = use_strap_q ? strap_mode : mode_q;
  assign wr         = bus_sel & bus_we;

  always_comb begin
    mode_d      = mode_q;
    use_strap_d = use_strap_q;
    dout_d      = dout_q;
    ien_d       = ien_q;
    itype_d     = itype_q;
    ipol_d      = ipol_q;
    buf_d       = buf_q;
    clr_mask    = '0;
    if (wr) begin
      case (bus_addr)
        A_MODE: begin
          mode_d      = bus_wdata[MW-1:0];
          use_strap_d = 1'b0;
        end
        A_DOUT:  dout_d   = bus_wdata[NPIN-1:0];
        A_IEN:   ien_d    = bus_wdata[NPIN-1:0];
        A_ITYPE: itype_d  = bus_wdata[NPIN-1:0];
        A_IPOL:  ipol_d   = bus_wdata[NPIN-1:0];
        A_IPEND: clr_mask = bus_wdata[NPIN-1:0];
        A_BUF:   buf_d    = bus_wdata[NPIN-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      mode_q      <= '0;
      use_strap_q <= 1'b1;
      dout_q      <= '1;
      ien_q       <= '0;
      itype_q     <= '0;
      ipol_q      <= '0;
      buf_q       <= '0;
    end else begin
      mode_q      <= mode_d;
      use_strap_q <= use_strap_d;
      dout_q      <= dout_d;
      ien_q       <= ien_d;
      itype_q     <= itype_d;
      ipol_q      <= ipol_d;
      buf_q       <= buf_d;
    end
  end

  gpio_pad_ctrl #(.NPIN(NPIN)) u_pad (
    .mode_vec (mode_eff),
    .dout     (dout_q),
    .pad_out  (pad_out),
    .pad_oe   (pad_oe),
    .pad_pu   (pad_pu)
  );

  gpio_irq_det #(.NPIN(NPIN)) u_irq (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .lvl      (pin_sync),
    .ien      (ien_q),
    .itype    (itype_q),
    .ipol     (ipol_q),
    .clr_mask (clr_mask),
    .pend     (pend)
  );

  assign wake_req    = pend & ien_q;
  assign irq         = |wake_req;
  assign pad_schmitt = buf_q;

  always_comb begin
    case (bus_addr)
      A_MODE:  bus_rdata = DW'(mode_eff);
      A_DOUT:  bus_rdata = DW'(dout_q);
      A_PIN:   bus_rdata = DW'(pin_sync);
      A_IEN:   bus_rdata = DW'(ien_q);
      A_ITYPE: bus_rdata = DW'(itype_q);
      A_IPOL:  bus_rdata = DW'(ipol_q);
      A_IPEND: bus_rdata = DW'(pend);
      A_BUF:   bus_rdata = DW'(buf_q);
      default: bus_rdata = '0;
    endcase
  end

  for (genvar i = 0; i < NPIN; i++) begin : g_chk
    // R1
    strong_high_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (pad_oe[i] && pad_out[i]) |-> (mode_eff[2*i +: 2] == PM_PUSH));
  end

  // R6
  pu_vs_drive_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (pad_pu & pad_oe & pad_out) == '0);

  // R5
  strap_reset_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    use_strap_q |-> (pad_pu == {NPIN{strap_quasi}}));

  // R10
  irq_en_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    irq |-> (|ien_q));
endmodule

// File: tb/sim_gpio_quad_port.sv
module sim_gpio_quad_port;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        strap_quasi;
  logic        bus_sel, bus_we;
  logic [3:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic [15:0] pad_in, pad_out, pad_oe, pad_pu, pad_schmitt, wake_req;
  logic        irq;

  int checks = 0;
  int fails  = 0;

  // {mode[1:0], dout, exp_oe, exp_out, exp_pu}
  localparam logic [5:0] VEC [8] = '{
    6'b00_0_000, 6'b00_1_000,
    6'b01_0_100, 6'b01_1_110,
    6'b10_0_100, 6'b10_1_000,
    6'b11_0_101, 6'b11_1_001
  };

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_quad_port u0 (
    .clk(clk), .rst_n(rst_n), .strap_quasi(strap_quasi),
    .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu),
    .pad_schmitt(pad_schmitt), .irq(irq), .wake_req(wake_req)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic do_reset(input logic strap);
    rst_n = 1'b0;
    strap_quasi = strap;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  function automatic string mode_tag(input logic [1:0] m);
    case (m)
      2'b00: return "R4";
      2'b01: return "R1";
      2'b10: return "R2";
      default: return "R3";
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [31:0] r;
    bus_sel = 0; bus_we = 0; bus_addr = 0; bus_wdata = 0; pad_in = 16'h0000;

    // R5 reset with strap 0
    do_reset(1'b0);
    rd(4'd0, r); check("R5 mode strap0", r, 32'h0);
    rd(4'd1, r); check("R5 dout reset", r, 32'h0000FFFF);
    check("R5 oe strap0", {16'h0, pad_oe}, 32'h0);
    check("R5 pu strap0", {16'h0, pad_pu}, 32'h0);
    rd(4'd6, r); check("R5 ipend reset", r, 32'h0);
    check("R5 irq reset", {31'h0, irq}, 32'h0);

    // R5 reset with strap 1
    do_reset(1'b1);
    rd(4'd0, r); check("R5 mode strap1", r, 32'hFFFFFFFF);
    check("R5 pu strap1", {16'h0, pad_pu}, 32'h0000FFFF);
    check("R5 oe strap1", {16'h0, pad_oe}, 32'h0);

    // vector table: R1 R2 R3 R4 R6
    for (int k = 0; k < 8; k++) begin
      logic [1:0] m;
      m = VEC[k][5:4];
      wr(4'd0, {16{m}});
      wr(4'd1, {16'h0, {16{VEC[k][3]}}});
      check({mode_tag(m), " oe"},  {16'h0, pad_oe},  {16'h0, {16{VEC[k][2]}}});
      check({mode_tag(m), " out"}, {16'h0, pad_out}, {16'h0, {16{VEC[k][1]}}});
      check("R6 pu", {16'h0, pad_pu}, {16'h0, {16{VEC[k][0]}}});
    end

    // R1 R6 per-pin independence with mixed modes
    wr(4'd0, 32'hE4E4E4E4);
    wr(4'd1, 32'h0);
    check("R1 mixed oe d0", {16'h0, pad_oe}, 32'h0000EEEE);
    check("R6 mixed pu", {16'h0, pad_pu}, 32'h00008888);
    wr(4'd1, 32'hFFFF);
    check("R1 mixed oe d1", {16'h0, pad_oe}, 32'h00002222);
    check("R1 mixed out d1", {16'h0, pad_out}, 32'h00002222);

    // R4 synchronizer latency
    wr(4'd0, 32'h0);
    pad_in = 16'hA5C3;
    @(negedge clk); rd(4'd2, r); check("R4 pin after 1 edge", r, 32'h0);
    @(negedge clk); rd(4'd2, r); check("R4 pin after 2 edges", r, 32'h0000A5C3);

    // R7 edge interrupts
    pad_in = 16'h0000;
    repeat (4) @(negedge clk);
    wr(4'd4, 32'h0);
    wr(4'd5, 32'h0001);
    wr(4'd3, 32'h0003);
    pad_in = 16'h0001;
    repeat (2) @(negedge clk); rd(4'd6, r); check("R7 rise not yet", r, 32'h0);
    @(negedge clk); rd(4'd6, r); check("R7 rise latched", r, 32'h1);
    check("R10 irq on", {31'h0, irq}, 32'h1);
    check("R11 wake pin0", {16'h0, wake_req}, 32'h1);
    pad_in = 16'h0000;
    repeat (4) @(negedge clk);
    wr(4'd6, 32'h0001);
    rd(4'd6, r); check("R8 cleared", r, 32'h0);
    check("R10 irq off", {31'h0, irq}, 32'h0);
    pad_in = 16'h0002;
    repeat (4) @(negedge clk); rd(4'd6, r); check("R7 opposite edge ignored", r, 32'h0);
    pad_in = 16'h0000;
    repeat (2) @(negedge clk); rd(4'd6, r); check("R7 fall not yet", r, 32'h0);
    @(negedge clk); rd(4'd6, r); check("R7 fall latched", r, 32'h2);

    // R8 partial clear
    wr(4'd6, 32'h0001);
    rd(4'd6, r); check("R8 zero bit kept", r, 32'h2);
    wr(4'd6, 32'h0002);
    rd(4'd6, r); check("R8 one bit cleared", r, 32'h0);

    // R10 disabled pin
    pad_in = 16'h0004; repeat (4) @(negedge clk);
    pad_in = 16'h0000; repeat (4) @(negedge clk);
    rd(4'd6, r); check("R10 disabled pin no pend", r, 32'h0);
    check("R10 irq stays low", {31'h0, irq}, 32'h0);

    // R9 level interrupt on pin 4, active high
    wr(4'd4, 32'h0010);
    wr(4'd5, 32'h0011);
    wr(4'd3, 32'h0013);
    rd(4'd6, r); check("R9 level idle", r, 32'h0);
    pad_in = 16'h0010;
    @(negedge clk); rd(4'd6, r); check("R9 level not yet", r, 32'h0);
    @(negedge clk); rd(4'd6, r); check("R9 level active", r, 32'h10);
    check("R11 wake pin4", {16'h0, wake_req}, 32'h10);
    wr(4'd6, 32'h0010);
    rd(4'd6, r); check("R9 w1c no effect", r, 32'h10);
    pad_in = 16'h0000;
    repeat (2) @(negedge clk); rd(4'd6, r); check("R9 level released", r, 32'h0);
    check("R11 wake off", {16'h0, wake_req}, 32'h0);

    // R12 buffer type pass-through
    wr(4'd7, 32'h5A5A);
    check("R12 schmitt", {16'h0, pad_schmitt}, 32'h00005A5A);
    rd(4'd7, r); check("R12 readback", r, 32'h00005A5A);

    // R13 unmapped read
    rd(4'd9, r); check("R13 unmapped", r, 32'h0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule